// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable-logic device. It takes the sum-of-products value already formed by the logic array and decides how that value reaches a bidirectional pin. Two configuration bits choose between a registered path (through a D flip-flop) and a combinational path (flip-flop bypassed), and between active-high and active-low pin polarity. A separate product term enables the pin driver. When the driver is off, the pin is left to outside logic and acts as an input. A feedback signal returns either the register contents or the combinational value, or the pin value, to the array.

The flip-flop is a two-state machine with states `BIT_CLR` and `BIT_SET`. It has three transitions. The asynchronous clear forces `BIT_CLR` at once, from either state. A synchronous preset moves to `BIT_SET` on the rising edge. A plain load moves to `BIT_SET` or `BIT_CLR` on the rising edge, following the sum value. The clock, the clear and the preset are shared by every cell of the device. The configuration codes are `CFG_REG_ACT_LOW` (00), `CFG_REG_ACT_HIGH` (01), `CFG_COMB_ACT_LOW` (10) and `CFG_COMB_ACT_HIGH` (11). A bit that reads 1 is an erased cell and a bit that reads 0 is a programmed cell. The pin driver is an inverting stage, so the four selectable data inputs already carry inverted values.

Top module: `io_macrocell`

## Requirements
- R1: With cfg_s1=0, the pin is driven from the flip-flop state. It changes only after a rising clock edge or an asynchronous clear.
- R2: With cfg_s1=1, the flip-flop is bypassed and the pin follows sum_in in the same cycle.
- R3: With cfg_s0=1, the driven pin equals the selected level (active high). With cfg_s0=0, the pin is its complement (active low). The code {cfg_s1,cfg_s0} indexes the output selector, with 2'b10 choosing the inverted-register-bypass input 2.
- R4: On a rising clock edge with arst=0 and spre=0, the flip-flop takes the value of sum_in.
- R5: On a rising clock edge with arst=0 and spre=1, the flip-flop becomes 1 whatever sum_in is.
- R6: While arst=1, the flip-flop is 0 at once, without waiting for a clock edge. The clear wins over spre.
- R7: pin_oe equals oe_term. While oe_term=0, pin_out is held at 0.
- R8: With cfg_s1=0, fb_out equals the flip-flop state, whether or not the pin is enabled.
- R9: With cfg_s1=1, fb_out equals sum_in while oe_term=1. It equals pin_in while oe_term=0, so that the pin serves as an array input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device-wide clock, rising edge active |
| arst | input | 1 | Device-wide asynchronous clear, active high |
| spre | input | 1 | Device-wide synchronous preset, active high |
| sum_in | input | 1 | ORed product terms from the array |
| cfg_s1 | input | 1 | 1 = bypass the flip-flop, 0 = registered |
| cfg_s0 | input | 1 | 1 = active-high pin, 0 = active-low pin |
| oe_term | input | 1 | Product term enabling the pin driver |
| pin_in | input | 1 | Value present on the pin when not driven |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback signal to the array |

## Verification
One corner case is the clear arriving in the middle of a cycle while preset is also high. A design that synchronised the clear, or gave preset priority, would show a 1 on a registered pin where 0 is expected. A second is a preset with sum_in=0. A design that ignored preset, or ORed it wrongly, would load 0. Polarity is exercised in all four codes. A swapped index or a missing inversion flips the pin in exactly one or two modes. Feedback is compared with the driver disabled in both modes: a selector that ignored the enable would return sum_in instead of pin_in in bypass mode, and a registered feedback that followed the pin would break the state loop.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
    localparam int CFG_BITS = 2;

    typedef enum logic [CFG_BITS-1:0] {
        CFG_REG_ACT_LOW   = 2'b00,
        CFG_REG_ACT_HIGH  = 2'b01,
        CFG_COMB_ACT_LOW  = 2'b10,
        CFG_COMB_ACT_HIGH = 2'b11
    } cfg_e;

    typedef enum logic {
        BIT_CLR = 1'b0,
        BIT_SET = 1'b1
    } bit_state_e;
endpackage

// File: rtl/mcell_reg.sv
module mcell_reg
    import mcell_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic spre,
    input  logic d,
    output logic q
);
    bit_state_e st, st_nxt;

    // state register: clear is asynchronous and dominant
    always_ff @(posedge clk or posedge arst) begin
        if (arst) st <= BIT_CLR;
        else      st <= st_nxt;
    end

    // next state: preset beats load
    always_comb begin
        unique case ({spre, d})
            2'b10, 2'b11: st_nxt = BIT_SET;
            2'b01:        st_nxt = BIT_SET;
            default:      st_nxt = BIT_CLR;
        endcase
    end

    always_comb q = (st == BIT_SET);

    p_preset_r5: assert property (@(posedge clk) disable iff (arst)
        spre |=> q);
    p_load_r4: assert property (@(posedge clk) disable iff (arst)
        !spre |=> (q == $past(d)));
endmodule

// File: rtl/mcell_outmux.sv
module mcell_outmux
    import mcell_pkg::*;
#(
    parameter int SEL_W = CFG_BITS
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             q,
    input  logic             sum,
    input  logic             oe,
    output logic             pin_out,
    output logic             pin_oe
);
    localparam int N_IN = 1 << SEL_W;

    logic [N_IN-1:0] din;

    // data input k: bit 1 of k picks bypass, bit 0 picks the pre-inverted
    // copy that the inverting driver turns back into active high
    for (genvar k = 0; k < N_IN; k++) begin : g_din
        localparam logic [SEL_W-1:0] KV = SEL_W'(k);
        always_comb begin
            din[k] = KV[SEL_W-1] ? sum : q;
            if (KV[0]) din[k] = ~din[k];
        end
    end

    // inverting tristate driver
    always_comb begin
        pin_oe  = oe;
        pin_out = oe ? ~din[sel] : 1'b0;
    end
endmodule

// File: rtl/mcell_fbsel.sv
module mcell_fbsel #(
    parameter bit PIN_FB_WHEN_INPUT = 1'b1
) (
    input  logic bypass,
    input  logic q,
    input  logic sum,
    input  logic oe,
    input  logic pin_in,
    output logic fb
);
    logic comb_src;

    if (PIN_FB_WHEN_INPUT) begin : g_pinfb
        always_comb comb_src = oe ? sum : pin_in;
    end else begin : g_sumfb
        always_comb comb_src = sum;
    end

    always_comb fb = bypass ? comb_src : q;
endmodule

// File: rtl/io_macrocell.sv
module io_macrocell
    import mcell_pkg::*;
#(
    parameter bit PIN_FB_WHEN_INPUT = 1'b1
) (
    input  logic clk,
    input  logic arst,
    input  logic spre,
    input  logic sum_in,
    input  logic cfg_s1,
    input  logic cfg_s0,
    input  logic oe_term,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_out
);
    cfg_e cfg;
    logic q;

    always_comb cfg = cfg_e'({cfg_s1, cfg_s0});

    mcell_reg u_reg (
        .clk  (clk),
        .arst (arst),
        .spre (spre),
        .d    (sum_in),
        .q    (q)
    );

    mcell_outmux #(.SEL_W(CFG_BITS)) u_mux (
        .sel     (cfg),
        .q       (q),
        .sum     (sum_in),
        .oe      (oe_term),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    mcell_fbsel #(.PIN_FB_WHEN_INPUT(PIN_FB_WHEN_INPUT)) u_fb (
        .bypass (cfg_s1),
        .q      (q),
        .sum    (sum_in),
        .oe     (oe_term),
        .pin_in (pin_in),
        .fb     (fb_out)
    );

    p_regpath_r1: assert property (@(posedge clk) disable iff (arst)
        (oe_term && cfg == CFG_REG_ACT_HIGH) |-> (pin_out == q));
    p_polarity_r3: assert property (@(posedge clk) disable iff (arst)
        (oe_term && cfg == CFG_COMB_ACT_LOW) |-> (pin_out != sum_in));
    p_bypass_r2: assert property (@(posedge clk) disable iff (arst)
        (oe_term && cfg == CFG_COMB_ACT_HIGH) |-> (pin_out == sum_in));
    p_float_r7: assert property (@(posedge clk) disable iff (arst)
        !oe_term |-> (!pin_out && !pin_oe));
    p_fbreg_r8: assert property (@(posedge clk) disable iff (arst)
        !cfg_s1 |-> (fb_out == q));
endmodule

// File: tb/sim_io_macrocell.sv
module sim_io_macrocell;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic clk = 1'b0;
    logic arst, spre, sum_in, cfg_s1, cfg_s0, oe_term, pin_in;
    logic pin_out, pin_oe, fb_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic  mq;
    string reg_tag = "R6";

    always #(CLK_PERIOD/2) clk = ~clk;

    io_macrocell u0 (
        .clk(clk), .arst(arst), .spre(spre), .sum_in(sum_in),
        .cfg_s1(cfg_s1), .cfg_s0(cfg_s0), .oe_term(oe_term),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check mid-low phase, model update at posedge
    task automatic step(input logic a, input logic p, input logic s,
                        input logic c1, input logic c0, input logic oe,
                        input logic pi);
        logic lvl, exp_pin, exp_fb;
        @(negedge clk);
        arst = a; spre = p; sum_in = s; cfg_s1 = c1; cfg_s0 = c0;
        oe_term = oe; pin_in = pi;
        if (a) begin
            mq = 1'b0;
            reg_tag = "R6";
        end
        #1;
        lvl     = c1 ? s : mq;
        exp_pin = oe ? (c0 ? lvl : ~lvl) : 1'b0;
        if (c1)
            exp_fb = oe ? s : pi;
        else
            exp_fb = mq;
        if (!oe)     chk("R7 pin_out", pin_out, exp_pin);
        else if (c1) chk("R2/R3 pin_out", pin_out, exp_pin);
        else         chk({"R1/R3 pin_out after ", reg_tag}, pin_out, exp_pin);
        chk("R7 pin_oe", pin_oe, oe);
        if (c1) chk("R9 fb_out", fb_out, exp_fb);
        else    chk({"R8 fb_out after ", reg_tag}, fb_out, exp_fb);
        @(posedge clk);
        if (!a) begin
            if (p) begin mq = 1'b1; reg_tag = "R5"; end
            else   begin mq = s;    reg_tag = "R4"; end
        end
    endtask

    initial begin
        arst = 1'b1; spre = 1'b0; sum_in = 1'b0; cfg_s1 = 1'b0; cfg_s0 = 1'b1;
        oe_term = 1'b1; pin_in = 1'b0; mq = 1'b0;
        // reset state, registered active high
        step(1, 0, 1, 0, 1, 1, 0);
        step(1, 1, 1, 0, 1, 1, 0);          // R6: clear beats preset
        // R4 loads in all registered modes
        step(0, 0, 1, 0, 1, 1, 0);
        step(0, 0, 0, 0, 1, 1, 1);
        step(0, 0, 1, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        // R5 preset with sum low
        step(0, 1, 0, 0, 1, 1, 0);
        step(0, 0, 0, 0, 1, 1, 0);
        // R6 clear mid-run while preset high
        step(1, 1, 1, 0, 1, 1, 0);
        step(0, 1, 0, 0, 0, 1, 0);
        // R2/R3 bypass both polarities, both sum values
        step(0, 0, 1, 1, 1, 1, 0);
        step(0, 0, 0, 1, 1, 1, 1);
        step(0, 0, 1, 1, 0, 1, 0);
        step(0, 0, 0, 1, 0, 1, 1);
        // R7/R9 driver off: pin used as input
        step(0, 0, 1, 1, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0, 1);
        // R8 register feedback with driver off
        step(0, 1, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [6:0] r;
            r = 7'($urandom);
            step(($urandom % 16) == 0, r[0], r[1], r[2], r[3], r[4] | r[5], r[6]);
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule